// File: doc/BRIEF.md
# Parallel EEPROM identification probe

This block finds out whether the expected parallel EEPROM is fitted on an asynchronous byte-wide bus. It drives the device's address, data, chip select, output enable and write enable lines. A single-cycle start pulse begins the probe. The block then writes a three-step unlock sequence that puts the device into its product identification mode and waits for the device to settle. Next it reads two identification bytes, one from device address 0 and one from device address 1, and compares them with constants. Last, it writes a second three-step sequence that returns the device to normal read mode, whatever the result, and waits again.

At the end, the block raises a one-cycle done pulse together with a match flag. The bus pulse widths and the settling interval are parameters counted in clocks. The default settling interval is about 10 ms at 200 MHz. A bench can therefore shrink the interval to a few clocks.

The controller is a state machine with these states: `S_IDLE`, `S_ENTER_CMD`, `S_ENTER_WAIT`, `S_READ_MFR`, `S_READ_DEV`, `S_EXIT_CMD`, `S_EXIT_WAIT` and `S_REPORT`. Its transitions are:
- `S_IDLE` to `S_ENTER_CMD` on start.
- `S_ENTER_CMD` to `S_ENTER_WAIT` when the third write completes.
- `S_ENTER_WAIT` to `S_READ_MFR` when the timer expires.
- `S_READ_MFR` to `S_READ_DEV` when the first read completes.
- `S_READ_DEV` to `S_EXIT_CMD` when the second read completes.
- `S_EXIT_CMD` to `S_EXIT_WAIT` when the third write completes.
- `S_EXIT_WAIT` to `S_REPORT` when the timer expires.
- `S_REPORT` to `S_IDLE` unconditionally.

A bus-cycle engine below the controller runs its own state sequence for every bus operation: `B_IDLE`, then `B_SETUP`, then `B_STROBE`, then `B_HOLD`, then back to `B_IDLE`.

Top module: `eeprom_id_probe`

## Requirements
- R1: After reset and whenever the block is idle, `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are 1, `mem_dq_oe_o` is 0 and `done_o` is 0.
- R2: The entry sequence is three writes in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, then 0x90 to 0x5555. The idle cycle of the first write is the first cycle after the clock edge that accepts start.
- R3: Every bus operation has a fixed layout. It starts with one idle cycle (chip select high). Then comes one setup cycle with chip select low and both strobes high. Then comes the strobe phase: for a write, `mem_we_n_o` is low for WE_CLKS cycles; for a read, `mem_oe_n_o` is low for RD_CLKS cycles. Then comes one hold cycle with chip select low and both strobes high. Address and write data stay stable from setup to hold, and `mem_dq_oe_o` is 1 over all of a write.
- R4: After the third entry write, the bus stays idle for exactly WAIT_CLKS cycles before the first read.
- R5: The two reads go to address 0 and then address 1. `mem_dq_oe_o` stays 0 during reads. Each byte is taken from `mem_dq_i` in the last cycle in which `mem_oe_n_o` is low.
- R6: After the second read, the exit sequence is written: 0xAA to 0x5555, 0x55 to 0x2AAA, then 0xF0 to 0x5555. The bus then stays idle for WAIT_CLKS cycles. The exit sequence is written whether or not the bytes matched.
- R7: `done_o` is high for exactly one cycle, the cycle after the exit wait. In that cycle `match_o` takes the value (byte at address 0 == MFR_ID and byte at address 1 == DEV_ID), with defaults 0xBF and 0x12. `match_o` holds that value until the next done pulse and is 0 after reset.
- R8: A start pulse that arrives while a probe is running is ignored and leaves the bus sequence unchanged. This includes a start in the done cycle. A start in the cycle after done is accepted.
- R9: `mem_oe_n_o` and `mem_we_n_o` are never low together, and chip select is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| mem_addr_o | output | ADDR_W | Device address |
| mem_dq_o | output | 8 | Write data to the device |
| mem_dq_oe_o | output | 1 | Drive enable for the data lines |
| mem_dq_i | input | 8 | Read data from the device |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable (read strobe), active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| match_o | output | 1 | Identification result, valid from done onwards |

## Verification
The assertions take for granted that reset is held low long enough for the first clock edge to see it. They also take for granted that `mem_dq_i` only matters in read strobe cycles. They make no assumption about when `start_i` arrives, because an ignored start has to leave every bus property intact. The stimulus raises start for a single cycle at the falling clock edge. It changes the modelled device's identification bytes only while the block is idle, so that the value returned during a read strobe is one defined byte per address.

// File: rtl/eid_pkg.sv
package eid_pkg;

    localparam int DQ_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENTER_CMD,
        S_ENTER_WAIT,
        S_READ_MFR,
        S_READ_DEV,
        S_EXIT_CMD,
        S_EXIT_WAIT,
        S_REPORT
    } probe_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_SETUP,
        B_STROBE,
        B_HOLD
    } bus_state_t;

    typedef struct packed {
        logic [15:0]     addr;
        logic [DQ_W-1:0] data;
    } cmd_word_t;

    localparam logic [15:0]     UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0]     UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [DQ_W-1:0] KEY_FIRST     = 8'hAA;
    localparam logic [DQ_W-1:0] KEY_SECOND    = 8'h55;
    localparam logic [DQ_W-1:0] OP_ID_ENTER   = 8'h90;
    localparam logic [DQ_W-1:0] OP_ID_LEAVE   = 8'hF0;

    // Command word for step 0..2 of either the entry or the exit sequence.
    function automatic cmd_word_t cmd_word(input logic [1:0] step, input logic leaving);
        cmd_word_t w;
        case (step)
            2'd0:    begin w.addr = UNLOCK_ADDR_A; w.data = KEY_FIRST;  end
            2'd1:    begin w.addr = UNLOCK_ADDR_B; w.data = KEY_SECOND; end
            default: begin
                w.addr = UNLOCK_ADDR_A;
                w.data = leaving ? OP_ID_LEAVE : OP_ID_ENTER;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/eid_bus_cycle.sv
module eid_bus_cycle
    import eid_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int WE_CLKS = 2,
    parameter int RD_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DQ_W-1:0]   wdata_i,
    output logic              done_o,
    output logic [DQ_W-1:0]   rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DQ_W-1:0]   bus_dq_o,
    output logic              bus_dq_oe_o,
    input  logic [DQ_W-1:0]   bus_dq_i,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o
);

    localparam int MAX_CLKS = (WE_CLKS > RD_CLKS) ? WE_CLKS : RD_CLKS;
    localparam int CW       = $clog2(MAX_CLKS + 1);
    localparam logic [CW-1:0] WE_LAST = CW'(WE_CLKS - 1);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_CLKS - 1);

    bus_state_t        bstate;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DQ_W-1:0]   data_q;
    logic              rd_q;
    logic [DQ_W-1:0]   rdata_q;
    logic              strobe_last;

    assign strobe_last = rd_q ? (cnt == RD_LAST) : (cnt == WE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bstate  <= B_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (bstate)
                B_IDLE: begin
                    if (req_i) begin
                        bstate <= B_SETUP;
                        addr_q <= addr_i;
                        data_q <= wdata_i;
                        rd_q   <= rd_i;
                        cnt    <= '0;
                    end
                end
                B_SETUP: bstate <= B_STROBE;
                B_STROBE: begin
                    if (strobe_last) begin
                        bstate <= B_HOLD;
                        if (rd_q) rdata_q <= bus_dq_i;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                B_HOLD: bstate <= B_IDLE;
                default: bstate <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        ce_n_o      = (bstate == B_IDLE);
        we_n_o      = !((bstate == B_STROBE) && !rd_q);
        oe_n_o      = !((bstate == B_STROBE) && rd_q);
        bus_dq_oe_o = (bstate != B_IDLE) && !rd_q;
        bus_addr_o  = addr_q;
        bus_dq_o    = data_q;
        done_o      = (bstate == B_HOLD);
        rdata_o     = rdata_q;
    end

endmodule

// File: rtl/eid_wait_timer.sv
module eid_wait_timer #(
    parameter int WAIT_CLKS = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CLKS - 1);

    logic [CW-1:0] cnt;

    assign expired_o = run_i && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!run_i)    cnt <= '0;
        else if (!expired_o) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/eeprom_id_probe.sv
module eeprom_id_probe
    import eid_pkg::*;
#(
    parameter int          ADDR_W    = 18,
    parameter int          WE_CLKS   = 2,
    parameter int          RD_CLKS   = 2,
    parameter int          WAIT_CLKS = 2_000_000,
    parameter logic [7:0]  MFR_ID    = 8'hBF,
    parameter logic [7:0]  DEV_ID    = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [7:0]        mem_dq_i,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic              done_o,
    output logic              match_o
);

    probe_state_t      state, state_nx;
    logic [1:0]        step;
    logic [DQ_W-1:0]   mfr_q;
    logic              id_ok_q;
    logic              match_q;

    logic              op_req, op_rd, op_done;
    logic [ADDR_W-1:0] op_addr;
    logic [DQ_W-1:0]   op_data, op_rdata;
    logic              wait_run, wait_expired;
    logic              in_cmd;
    cmd_word_t         cw;

    assign in_cmd   = (state == S_ENTER_CMD) || (state == S_EXIT_CMD);
    assign wait_run = (state == S_ENTER_WAIT) || (state == S_EXIT_WAIT);

    eid_bus_cycle #(
        .ADDR_W (ADDR_W),
        .WE_CLKS(WE_CLKS),
        .RD_CLKS(RD_CLKS)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (op_req),
        .rd_i       (op_rd),
        .addr_i     (op_addr),
        .wdata_i    (op_data),
        .done_o     (op_done),
        .rdata_o    (op_rdata),
        .bus_addr_o (mem_addr_o),
        .bus_dq_o   (mem_dq_o),
        .bus_dq_oe_o(mem_dq_oe_o),
        .bus_dq_i   (mem_dq_i),
        .ce_n_o     (mem_ce_n_o),
        .oe_n_o     (mem_oe_n_o),
        .we_n_o     (mem_we_n_o)
    );

    eid_wait_timer #(
        .WAIT_CLKS(WAIT_CLKS)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wait_run),
        .expired_o(wait_expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start_i)                    state_nx = S_ENTER_CMD;
            S_ENTER_CMD:  if (op_done && step == 2'd2)    state_nx = S_ENTER_WAIT;
            S_ENTER_WAIT: if (wait_expired)               state_nx = S_READ_MFR;
            S_READ_MFR:   if (op_done)                    state_nx = S_READ_DEV;
            S_READ_DEV:   if (op_done)                    state_nx = S_EXIT_CMD;
            S_EXIT_CMD:   if (op_done && step == 2'd2)    state_nx = S_EXIT_WAIT;
            S_EXIT_WAIT:  if (wait_expired)               state_nx = S_REPORT;
            S_REPORT:                                     state_nx = S_IDLE;
            default:                                      state_nx = S_IDLE;
        endcase
    end

    // State register, command step and captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            step    <= 2'd0;
            mfr_q   <= '0;
            id_ok_q <= 1'b0;
            match_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_cmd && op_done)
                step <= (step == 2'd2) ? 2'd0 : step + 2'd1;
            if (state == S_READ_MFR && op_done)
                mfr_q <= op_rdata;
            if (state == S_READ_DEV && op_done)
                id_ok_q <= (mfr_q == MFR_ID) && (op_rdata == DEV_ID);
            if (state == S_EXIT_WAIT && wait_expired)
                match_q <= id_ok_q;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        op_req  = 1'b0;
        op_rd   = 1'b0;
        op_addr = '0;
        op_data = '0;
        done_o  = 1'b0;
        cw      = cmd_word(step, state == S_EXIT_CMD);
        unique case (state)
            S_ENTER_CMD, S_EXIT_CMD: begin
                op_req  = 1'b1;
                op_addr = ADDR_W'(cw.addr);
                op_data = cw.data;
            end
            S_READ_MFR: begin
                op_req  = 1'b1;
                op_rd   = 1'b1;
                op_addr = ADDR_W'(0);
            end
            S_READ_DEV: begin
                op_req  = 1'b1;
                op_rd   = 1'b1;
                op_addr = ADDR_W'(1);
            end
            S_REPORT: done_o = 1'b1;
            default: ;
        endcase
        match_o = match_q;
    end

endmodule

// File: rtl/eid_probe_chk.sv
module eid_probe_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_dq_o,
    input logic              mem_dq_oe_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic              done_o
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n_o && !mem_we_n_o));

    // R9
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n_o || !mem_we_n_o) |-> !mem_ce_n_o);

    // R3
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> ($stable(mem_addr_o) && $stable(mem_dq_o) && !$past(mem_ce_n_o)));

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (!mem_ce_n_o && $stable(mem_addr_o) && $stable(mem_dq_o)));

    // R3
    write_drives_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_dq_oe_o);

    // R5
    read_releases_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

endmodule

bind eeprom_id_probe eid_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .mem_we_n_o (mem_we_n_o),
    .done_o     (done_o)
);

// File: tb/eeprom_id_probe_tb.sv
`timescale 1ns/1ps
module eeprom_id_probe_tb;

    localparam int AW = 18;
    localparam int WE = 3;
    localparam int RD = 2;
    localparam int WT = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_dq_o, mem_dq_i;
    logic          mem_dq_oe_o, mem_ce_n_o, mem_oe_n_o, mem_we_n_o;
    logic          done_o, match_o;

    logic [7:0]    dev_mfr = 8'hBF;
    logic [7:0]    dev_dev = 8'h12;

    int tests = 0;
    int fails = 0;
    int done_seen = 0;
    int runs_expected = 0;
    bit finished = 0;
    bit held_match = 0;

    always #2.5 clk = ~clk;

    eeprom_id_probe #(
        .ADDR_W(AW), .WE_CLKS(WE), .RD_CLKS(RD), .WAIT_CLKS(WT),
        .MFR_ID(8'hBF), .DEV_ID(8'h12)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
        .mem_dq_i(mem_dq_i), .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_we_n_o(mem_we_n_o), .done_o(done_o), .match_o(match_o)
    );

    // Device model: drives its ID bytes only while selected and read-strobed.
    always_comb begin
        if (!mem_ce_n_o && !mem_oe_n_o)
            mem_dq_i = (mem_addr_o == 0) ? dev_mfr : (mem_addr_o == 1) ? dev_dev : 8'h00;
        else
            mem_dq_i = 8'hEE;
    end

    typedef struct packed {
        logic          ce_n, oe_n, we_n, dq_oe, done, mt;
        logic [AW-1:0] addr;
        logic [7:0]    dout;
        logic [3:0]    tag;
    } exp_t;

    exp_t exp_q[$];

    function automatic string rname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic exp_t idle_e(input logic [3:0] t);
        exp_t e;
        e = '{ce_n:1, oe_n:1, we_n:1, dq_oe:0, done:0, mt:0, addr:'0, dout:'0, tag:t};
        return e;
    endfunction

    function automatic void push_write(input logic [AW-1:0] a, input logic [7:0] d, input logic [3:0] t);
        exp_t e;
        exp_q.push_back(idle_e(4'd3));
        e = '{ce_n:0, oe_n:1, we_n:1, dq_oe:1, done:0, mt:0, addr:a, dout:d, tag:4'd3};
        exp_q.push_back(e);
        for (int i = 0; i < WE; i++) begin
            e.we_n = 0; e.tag = t;
            exp_q.push_back(e);
        end
        e.we_n = 1; e.tag = 4'd3;
        exp_q.push_back(e);
    endfunction

    function automatic void push_read(input logic [AW-1:0] a);
        exp_t e;
        exp_q.push_back(idle_e(4'd3));
        e = '{ce_n:0, oe_n:1, we_n:1, dq_oe:0, done:0, mt:0, addr:a, dout:'0, tag:4'd5};
        exp_q.push_back(e);
        for (int i = 0; i < RD; i++) begin
            e.oe_n = 0;
            exp_q.push_back(e);
        end
        e.oe_n = 1;
        exp_q.push_back(e);
    endfunction

    function automatic void build_probe(input logic [7:0] m, input logic [7:0] d);
        exp_t e;
        push_write(18'h05555, 8'hAA, 4'd2);
        push_write(18'h02AAA, 8'h55, 4'd2);
        push_write(18'h05555, 8'h90, 4'd2);
        for (int i = 0; i < WT; i++) exp_q.push_back(idle_e(4'd4));
        push_read(18'h00000);
        push_read(18'h00001);
        push_write(18'h05555, 8'hAA, 4'd6);
        push_write(18'h02AAA, 8'h55, 4'd6);
        push_write(18'h05555, 8'hF0, 4'd6);
        for (int i = 0; i < WT; i++) exp_q.push_back(idle_e(4'd6));
        e = idle_e(4'd7);
        e.done = 1;
        e.mt = (m == 8'hBF) && (d == 8'h12);
        exp_q.push_back(e);
    endfunction

    // Reference model advances one entry per clock; a start is taken only when idle (R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
        end else if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
        end else if (start_i) begin
            build_probe(dev_mfr, dev_dev);
            runs_expected++;
        end
        if (rst_n && done_o) done_seen++;
    end

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !finished) begin
            e = (exp_q.size() > 0) ? exp_q[0] : idle_e(4'd1);
            if (e.done) held_match = e.mt;
            tests++;
            if (mem_ce_n_o !== e.ce_n || mem_oe_n_o !== e.oe_n || mem_we_n_o !== e.we_n ||
                mem_dq_oe_o !== e.dq_oe || done_o !== e.done ||
                (!e.ce_n && mem_addr_o !== e.addr) || (e.dq_oe && mem_dq_o !== e.dout)) begin
                fails++;
                $display("FAIL %s t=%0t got ce%b oe%b we%b dqoe%b done%b a=%h d=%h exp ce%b oe%b we%b dqoe%b done%b a=%h d=%h",
                    rname(e.tag), $time, mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, done_o,
                    mem_addr_o, mem_dq_o, e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.done, e.addr, e.dout);
            end
            tests++;
            if (match_o !== held_match) begin
                fails++;
                $display("FAIL R7 t=%0t match_o got %b exp %b", $time, match_o, held_match);
            end
            tests++;
            if ((!mem_oe_n_o && !mem_we_n_o) || ((!mem_oe_n_o || !mem_we_n_o) && mem_ce_n_o)) begin
                fails++;
                $display("FAIL R9 t=%0t strobes oe%b we%b ce%b exp exclusive with ce low",
                    $time, mem_oe_n_o, mem_we_n_o, mem_ce_n_o);
            end
        end
    end

    task automatic check(input string r, input logic [31:0] got, input logic [31:0] expv);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", r, got, expv);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_probe(input logic [7:0] m, input logic [7:0] d, input logic expm);
        @(negedge clk); dev_mfr = m; dev_dev = d;
        pulse_start();
        wait_idle();
        check("R7 match", {31'd0, match_o}, {31'd0, expm});
        check("R6 exit issued / done count", done_seen, runs_expected);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset ce_n", {31'd0, mem_ce_n_o}, 32'd1);
        check("R1 reset we_n/oe_n", {30'd0, mem_we_n_o, mem_oe_n_o}, 32'd3);
        check("R1 reset done/match/dq_oe", {29'd0, done_o, match_o, mem_dq_oe_o}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2 R4 R5 R7: matching device
        run_probe(8'hBF, 8'h12, 1'b1);
        // R6: wrong device byte, exit still written
        run_probe(8'hBF, 8'h13, 1'b0);
        // R5: swapped bytes detect address order
        run_probe(8'h12, 8'hBF, 1'b0);
        run_probe(8'hBE, 8'h12, 1'b0);
        run_probe(8'hBF, 8'h12, 1'b1);
        // R8: starts during a running probe and in the done cycle are ignored
        @(negedge clk); dev_mfr = 8'hBF; dev_dev = 8'h55;
        pulse_start();
        repeat (30) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        while (exp_q.size() != 1) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 ignored starts", done_seen, runs_expected);
        check("R8 idle after ignored start", {31'd0, mem_ce_n_o}, 32'd1);
        check("R7 match after no-match", {31'd0, match_o}, 32'd0);
        // R8: start in the cycle after done is accepted
        dev_mfr = 8'hBF; dev_dev = 8'h12;
        pulse_start();
        while (exp_q.size() != 1) @(negedge clk);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R8 back-to-back accepted", {31'd0, mem_ce_n_o}, 32'd1);
        wait_idle();
        check("R8 back-to-back runs", done_seen, runs_expected);
        check("R8 back-to-back count", runs_expected, 32'd8);
        check("R7 final match", {31'd0, match_o}, 32'd1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule